// File: doc/BRIEF.md
# Multiplexer Stuck-At Test Sequencer

This block drives a complete stuck-at test of an n-to-1 multiplexer that is W bits wide and checks the result itself. A start request sets off one run. During the run the block drives the select code and every data input of the multiplexer under test, one vector per clock. At the end of each vector cycle it samples the multiplexer output and compares it with the word it predicted. Mismatches are counted, and the index of the first one is kept. When the run ends the block raises a one-cycle completion strobe, and a pass or fail verdict stays visible until the next start.

A run has exactly 2N vectors. The select codes step through a reflected Gray sequence from 0 upward, then retrace the same codes downward. The polarity alternates from one vector to the next, so the selected input always holds the word opposite to all the other inputs. The number of inputs N must be a power of two, at least 2.

Top module: `mux_test_seq`

## Requirements
- R1: A start seen while idle begins a run. busy is high from the next cycle for exactly 2N cycles. done is high for the single cycle right after busy falls. busy and done are never high together.
- R2: In busy cycle k (k counted from 0), muxSel equals j XOR (j>>1), where j = k for k < N and j = 2N-1-k otherwise.
- R3: Input i uses bits [i*W +: W] of muxData. In even busy cycles the selected input is all zeros and every other input is all ones. In odd busy cycles the selected input is all ones and every other input is all zeros.
- R4: At the end of each busy cycle the block compares muxOut with a word whose bits all equal that vector's polarity (0 for even k, 1 for odd k). errCount holds the number of vectors that did not match.
- R5: firstFailIdx holds the index k of the earliest mismatching vector of the run. It is 0 when no vector mismatched.
- R6: fail rises on the edge that records the first mismatch. pass is set at the end of a run only if no vector mismatched. pass, fail, errCount and firstFailIdx keep their values while idle, and the next accepted start clears them.
- R7: start asserted during a run is ignored: the run still lasts 2N cycles and its results are unchanged.
- R8: After reset busy, done, pass, fail, errCount and firstFailIdx are 0. Whenever busy is low, muxSel and muxData are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, acted on only while idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe marking the end of a run |
| muxSel | output | $clog2(N) | Select code driven to the multiplexer under test |
| muxData | output | N*W | All data inputs; input i uses bits [i*W +: W] |
| muxOut | input | W | Observed output of the multiplexer under test |
| pass | output | 1 | Last run had no mismatch |
| fail | output | 1 | Current or last run had at least one mismatch |
| errCount | output | $clog2(2N+1) | Number of mismatching vectors |
| firstFailIdx | output | $clog2(N)+1 | Index of the first mismatching vector |

## Verification
The bench places a behavioural multiplexer next to the sequencer and runs it under four conditions: fault free, a select bit stuck at one, one data bit stuck at zero on a single input, and an output bit stuck at one. The fault-free run checks the whole Gray walk, the polarity of every vector and a passing verdict. A stuck select fails on vector 0. A stuck output bit fails only on the even vectors, so errCount reaches N. The data-bit fault on input 3 fails only on the backward pass, at vector 13, which shows that the reversed walk with inverted polarity is needed. Further runs check that a start pulse in the middle of a run is ignored, and that a clean run after a failing one clears the verdict.

// File: rtl/mts_pkg.sv
package mts_pkg;

  // Control phases of one run.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mtsState_t;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic clr;     // start accepted: wipe counters and verdict
    logic apply;   // a vector is on the outputs this cycle
    logic finish;  // this vector is the last of the run
  } mtsStrobes_t;

endpackage

// File: rtl/mts_ctrl.sv
module mts_ctrl
  import mts_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  output mtsStrobes_t                strb,
  output logic [$clog2(N):0]         vecIdx,
  output logic                       busy,
  output logic                       done
);

  localparam int SELW = $clog2(N);
  localparam int IDXW = SELW + 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(2 * N - 1);

  mtsState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      vecIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RUN;
            vecIdx <= '0;
          end
        end
        ST_RUN: begin
          if (vecIdx == LAST_IDX) begin
            state <= ST_FIN;
          end else begin
            vecIdx <= vecIdx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clr    = (state == ST_IDLE) && start;
    strb.apply  = (state == ST_RUN);
    strb.finish = (state == ST_RUN) && (vecIdx == LAST_IDX);
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/mts_datapath.sv
module mts_datapath
  import mts_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mtsStrobes_t                  strb,
  input  logic [$clog2(N):0]           vecIdx,
  output logic [$clog2(N)-1:0]         muxSel,
  output logic [N*W-1:0]               muxData,
  input  logic [W-1:0]                 muxOut,
  output logic                         pass,
  output logic                         fail,
  output logic [$clog2(2*N+1)-1:0]     errCount,
  output logic [$clog2(N):0]           firstFailIdx
);

  localparam int SELW = $clog2(N);
  localparam int IDXW = SELW + 1;
  localparam int CNTW = $clog2(2 * N + 1);

  logic [SELW-1:0] foldIdx;
  logic [SELW-1:0] graySel;
  logic            pol;
  logic [W-1:0]    expWord;
  logic            mismatch;

  // The upper half of the run mirrors the lower half: 2N-1-k equals ~k
  // in the low bits when N is a power of two.
  always_comb begin
    foldIdx  = vecIdx[IDXW-1] ? ~vecIdx[SELW-1:0] : vecIdx[SELW-1:0];
    graySel  = foldIdx ^ (foldIdx >> 1);
    pol      = vecIdx[0];
    expWord  = {W{pol}};
    mismatch = strb.apply && (muxOut != expWord);
  end

  assign muxSel = strb.apply ? graySel : '0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_lane
      always_comb begin
        if (!strb.apply) begin
          muxData[gi*W +: W] = '0;
        end else if (graySel == SELW'(gi)) begin
          muxData[gi*W +: W] = {W{pol}};
        end else begin
          muxData[gi*W +: W] = {W{~pol}};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount     <= '0;
      firstFailIdx <= '0;
      fail         <= 1'b0;
      pass         <= 1'b0;
    end else if (strb.clr) begin
      errCount     <= '0;
      firstFailIdx <= '0;
      fail         <= 1'b0;
      pass         <= 1'b0;
    end else begin
      if (mismatch) begin
        errCount <= errCount + CNTW'(1);
        fail     <= 1'b1;
        if (errCount == '0) begin
          firstFailIdx <= vecIdx;
        end
      end
      if (strb.finish) begin
        pass <= !mismatch && (errCount == '0);
      end
    end
  end

endmodule

// File: rtl/mux_test_seq.sv
module mux_test_seq
  import mts_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(N)-1:0]         muxSel,
  output logic [N*W-1:0]               muxData,
  input  logic [W-1:0]                 muxOut,
  output logic                         pass,
  output logic                         fail,
  output logic [$clog2(2*N+1)-1:0]     errCount,
  output logic [$clog2(N):0]           firstFailIdx
);

  mtsStrobes_t        strb;
  logic [$clog2(N):0] vecIdx;

  mts_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strb   (strb),
    .vecIdx (vecIdx),
    .busy   (busy),
    .done   (done)
  );

  mts_datapath #(.N(N), .W(W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .vecIdx       (vecIdx),
    .muxSel       (muxSel),
    .muxData      (muxData),
    .muxOut       (muxOut),
    .pass         (pass),
    .fail         (fail),
    .errCount     (errCount),
    .firstFailIdx (firstFailIdx)
  );

endmodule

// File: rtl/mux_test_seq_chk.sv
module mux_test_seq_chk #(
  parameter int N = 8,
  parameter int W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic [$clog2(N)-1:0]         muxSel,
  input logic [N*W-1:0]               muxData,
  input logic [W-1:0]                 muxOut,
  input logic                         pass,
  input logic                         fail,
  input logic [$clog2(2*N+1)-1:0]     errCount,
  input logic [$clog2(N):0]           firstFailIdx
);

  assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // Successive select codes differ in at most one bit (Gray walk and turnaround).
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($countones(muxSel ^ $past(muxSel)) <= 1));

  assert_err_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ((errCount == $past(errCount)) ||
                               (errCount == $past(errCount) + 1'b1)));

  assert_verdict_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass != fail));

  assert_fail_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (errCount != '0));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((muxSel == '0) && (muxData == '0)));

endmodule

bind mux_test_seq mux_test_seq_chk #(.N(N), .W(W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .muxSel       (muxSel),
  .muxData      (muxData),
  .muxOut       (muxOut),
  .pass         (pass),
  .fail         (fail),
  .errCount     (errCount),
  .firstFailIdx (firstFailIdx)
);

// File: tb/mux_test_seq_bench.sv
`timescale 1ns/1ps
module mux_test_seq_bench;

  localparam int N    = 8;
  localparam int W    = 8;
  localparam int SELW = $clog2(N);
  localparam int IDXW = SELW + 1;
  localparam int CNTW = $clog2(2 * N + 1);

  typedef struct packed {
    logic [SELW-1:0] sel;
    logic [N*W-1:0]  data;
  } vecItem_t;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic                busy, done, pass, fail;
  logic [SELW-1:0]     muxSel;
  logic [N*W-1:0]      muxData;
  logic [W-1:0]        muxOut;
  logic [CNTW-1:0]     errCount;
  logic [IDXW-1:0]     firstFailIdx;

  int faultMode = 0;
  int nChecks = 0;
  int nFails = 0;
  int busyCycles = 0;
  vecItem_t expQ[$];

  always #2.5 clk = ~clk;

  mux_test_seq #(.N(N), .W(W)) u_mux_test_seq (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .muxSel(muxSel), .muxData(muxData), .muxOut(muxOut), .pass(pass),
    .fail(fail), .errCount(errCount), .firstFailIdx(firstFailIdx)
  );

  // Behavioural multiplexer under test with optional injected faults.
  function automatic logic [W-1:0] mutModel(input logic [SELW-1:0] s,
                                            input logic [N*W-1:0] d, input int fm);
    logic [SELW-1:0] es;
    logic [W-1:0] o;
    es = (fm == 1) ? (s | SELW'(1)) : s;
    o  = d[es*W +: W];
    if (fm == 2 && es == SELW'(3)) o[0] = 1'b0;
    if (fm == 3) o[W-1] = 1'b1;
    return o;
  endfunction

  always_comb muxOut = mutModel(muxSel, muxData, faultMode);

  function automatic vecItem_t makeVec(input int k);
    vecItem_t it;
    int j;
    logic p;
    j = (k < N) ? k : (2 * N - 1 - k);
    it.sel = SELW'(j ^ (j >> 1));
    p = (k % 2) == 1;
    for (int i = 0; i < N; i++)
      it.data[i*W +: W] = (i == int'(it.sel)) ? {W{p}} : {W{~p}};
    return it;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected vector per busy cycle (R2, R3).
  always @(negedge clk) begin
    if (busy) begin
      busyCycles++;
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "busy with empty queue", busyCycles, 2 * N);
      end else begin
        vecItem_t e;
        e = expQ.pop_front();
        check(muxSel == e.sel, "R2", "select code", muxSel, e.sel);
        check(muxData == e.data, "R3", "data pattern", muxData, e.data);
      end
    end
  end

  // Driver: queue a full run, start it, wait for done, then check the verdict.
  task automatic runTest(input int fm, input bit midStart);
    int expErr = 0;
    int expFirst = 0;
    int cyc = 0;
    bit sawDone = 0;
    faultMode = fm;
    for (int k = 0; k < 2 * N; k++) begin
      vecItem_t it;
      it = makeVec(k);
      expQ.push_back(it);
      if (mutModel(it.sel, it.data, fm) != {W{logic'(k % 2)}}) begin
        if (expErr == 0) expFirst = k;
        expErr++;
      end
    end
    busyCycles = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      start = (midStart && cyc == 5);
      if (done) sawDone = 1;
    end
    start = 1'b0;
    check(sawDone, "R1", "done seen", sawDone, 1);
    check(busyCycles == 2 * N, midStart ? "R7" : "R1", "busy cycles", busyCycles, 2 * N);
    check(errCount == CNTW'(expErr), "R4", "error count", errCount, expErr);
    check(firstFailIdx == IDXW'(expFirst), "R5", "first fail index", firstFailIdx, expFirst);
    check(pass == (expErr == 0), "R6", "pass flag", pass, expErr == 0);
    check(fail == (expErr != 0), "R6", "fail flag", fail, expErr != 0);
    @(negedge clk);
    check(!done, "R1", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    check(pass == (expErr == 0) && fail == (expErr != 0), "R6", "verdict held",
          {pass, fail}, {expErr == 0, expErr != 0});
    check(errCount == CNTW'(expErr), "R6", "count held", errCount, expErr);
    check(muxSel == '0 && muxData == '0, "R8", "idle outputs", muxData, 0);
    check(expQ.size() == 0, "R2", "all vectors seen", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R8", "reset busy/done", {busy, done}, 0);
    check(!pass && !fail, "R8", "reset verdict", {pass, fail}, 0);
    check(errCount == 0 && firstFailIdx == 0, "R8", "reset counters", errCount, 0);
    check(muxSel == 0 && muxData == 0, "R8", "reset outputs", muxData, 0);

    runTest(0, 0);  // fault free: pass
    runTest(1, 0);  // select bit 0 stuck at 1: fails at vector 0
    runTest(2, 0);  // input 3 bit 0 stuck at 0: fails only at vector 13
    runTest(3, 0);  // output MSB stuck at 1: all even vectors fail
    runTest(0, 1);  // start mid-run ignored (R7), verdict cleared after fail (R6)
    runTest(2, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule